// File: doc/BRIEF.md
# Serial-link PHY reset and receive-PLL lock sequencer

This block brings a serial-link PHY out of reset and waits until its receive PLL reports lock. It has no direct access to the PHY. Every access goes through a separate control-register handshake master, which the block drives through a request/done command port. Each command is one of three kinds: latch an address, write data with no acknowledge expected, or read data.

An optional pre-stage comes first when `pre_en` is high at start. It releases an external power-down control, then pulses an external soft-reset control low and back high. The block then addresses the PHY clock-reset register and writes its reset bit. After that it polls. Each poll waits a programmable number of idle cycles, addresses the lane status register and reads it, until the receive-PLL-stable bit appears or the poll budget runs out.

The outcome is reported with a one-cycle `done` pulse and a result code. A handshake error from the master ends the sequence at once. The PHY cannot acknowledge the reset write itself, so the master completes that command type without waiting for the PHY.

Top module: `physeq_reset_lock`

## Requirements
- R1: After reset, `pwr_down` and `soft_rst` are 1, and `busy`, `done`, `cr_req` and `result` are all 0.
- R2: When `pre_en` is 1 at start, the pre-stage runs one step per cycle. In the cycle after start `pwr_down` is 0 and `soft_rst` is 1. In the next cycle `soft_rst` is 0. In the cycle after that `soft_rst` is 1 again and the first command is requested. `pwr_down` stays 0 until reset.
- R3: When `pre_en` is 0 at start, `pwr_down` and `soft_rst` keep their values, and the first command is requested in the cycle after start.
- R4: The first two commands are an address command (op 0) carrying 0x7F3F, then a write-without-acknowledge command (op 1) carrying 0x0001.
- R5: Every poll is an address command carrying 0x2003 followed directly by a read command (op 2). Each poll is preceded by exactly `GAP_CYC` cycles with `cr_req` low.
- R6: A read that returns bit 1 set ends the sequence with result 1 (locked). All other bits of the read data are ignored, so 0xFFFD does not end it.
- R7: If none of `MAX_POLLS` reads shows bit 1, the sequence ends after the last of them with result 2 (timeout).
- R8: A command completed with `cr_err` high ends the sequence with result 3 (link error), and no further command is requested.
- R9: A start pulse while `busy` is high is ignored. The command stream and the single `done` pulse are unchanged.
- R10: `busy` is high from the cycle after an accepted start until the sequence ends. `done` is high for exactly one cycle, with `busy` already low and `result` valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a sequence when idle |
| pre_en | input | 1 | Runs the external power-down/soft-reset pre-stage |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| result | output | 2 | 0 none, 1 locked, 2 timeout, 3 link error |
| pwr_down | output | 1 | External PHY power-down control |
| soft_rst | output | 1 | External PHY soft-reset control |
| cr_req | output | 1 | Command request to the register master |
| cr_op | output | 2 | 0 address, 1 write without acknowledge, 2 read |
| cr_wdata | output | 16 | Address or write data |
| cr_done | input | 1 | Command completion from the master |
| cr_err | input | 1 | Command failed, valid with `cr_done` |
| cr_rdata | input | 16 | Read data, valid with `cr_done` |

## Verification
A wrong state register shows up on the command port at the very next completed command. The wrong opcode or address appears, or a poll arrives after the wrong idle gap, so the scoreboard flags it within one transaction. A poll counter that is off by one changes the number of reads before timeout, which is visible at the final `done`. A broken lock decode either ends the sequence on the 0xFFFD filler or keeps polling past the locking read. In both cases the transaction stream diverges from the expected one at that same read.

// File: rtl/physeq_pkg.sv
`timescale 1ns/1ps
package physeq_pkg;
  typedef enum logic [1:0] {
    CR_ADDR        = 2'd0,
    CR_WRITE_NOACK = 2'd1,
    CR_READ        = 2'd2
  } cr_op_e;

  typedef enum logic [1:0] {
    RES_NONE    = 2'd0,
    RES_LOCKED  = 2'd1,
    RES_TIMEOUT = 2'd2,
    RES_LINKERR = 2'd3
  } seq_res_e;

  localparam logic [15:0] CLKRST_REG     = 16'h7F3F;
  localparam logic [15:0] CLKRST_RST_VAL = 16'h0001;
  localparam logic [15:0] LANE_STAT_REG  = 16'h2003;
  localparam int          PLL_LOCK_BIT   = 1;

  function automatic logic rx_pll_stable(input logic [15:0] stat);
    return stat[PLL_LOCK_BIT];
  endfunction
endpackage

// File: rtl/physeq_gap_timer.sv
`timescale 1ns/1ps
module physeq_gap_timer #(
  parameter int GAP_CYC = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int W = $clog2(GAP_CYC + 1);
  localparam logic [W-1:0] LAST = W'(GAP_CYC - 1);

  logic [W-1:0] cnt;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (!expired)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/physeq_poll_counter.sv
`timescale 1ns/1ps
module physeq_poll_counter #(
  parameter int MAX_POLLS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic last
);
  localparam int W = $clog2(MAX_POLLS + 1);
  localparam logic [W-1:0] LAST = W'(MAX_POLLS - 1);

  logic [W-1:0] cnt;

  assign last = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (bump)       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/physeq_reset_lock.sv
`timescale 1ns/1ps
module physeq_reset_lock
  import physeq_pkg::*;
#(
  parameter int GAP_CYC   = 15000,
  parameter int MAX_POLLS = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        pre_en,
  output logic        busy,
  output logic        done,
  output logic [1:0]  result,
  output logic        pwr_down,
  output logic        soft_rst,
  output logic        cr_req,
  output logic [1:0]  cr_op,
  output logic [15:0] cr_wdata,
  input  logic        cr_done,
  input  logic        cr_err,
  input  logic [15:0] cr_rdata
);
  typedef enum logic [3:0] {
    S_IDLE, S_PRE_RLO, S_PRE_RHI, S_RST_ADDR, S_RST_WR,
    S_GAP, S_POLL_ADDR, S_POLL_RD
  } state_e;

  state_e   state;
  seq_res_e res_q;
  logic     done_q;

  // named internal events
  logic start_ok, cmd_ack, cmd_fail, read_ack, poll_hit, poll_miss;
  logic gap_run, gap_expired, poll_last;

  assign start_ok  = (state == S_IDLE) && start;
  assign cmd_ack   = cr_req && cr_done;
  assign cmd_fail  = cmd_ack && cr_err;
  assign read_ack  = cmd_ack && !cr_err && (state == S_POLL_RD);
  assign poll_hit  = read_ack && rx_pll_stable(cr_rdata);
  assign poll_miss = read_ack && !rx_pll_stable(cr_rdata);
  assign gap_run   = (state == S_GAP);

  physeq_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .run(gap_run), .expired(gap_expired)
  );

  physeq_poll_counter #(.MAX_POLLS(MAX_POLLS)) u_polls (
    .clk(clk), .rst_n(rst_n), .clear(start_ok), .bump(poll_miss), .last(poll_last)
  );

  always_comb begin
    cr_req   = 1'b0;
    cr_op    = CR_ADDR;
    cr_wdata = 16'h0000;
    unique case (state)
      S_RST_ADDR:  begin cr_req = 1'b1; cr_op = CR_ADDR;        cr_wdata = CLKRST_REG;     end
      S_RST_WR:    begin cr_req = 1'b1; cr_op = CR_WRITE_NOACK; cr_wdata = CLKRST_RST_VAL; end
      S_POLL_ADDR: begin cr_req = 1'b1; cr_op = CR_ADDR;        cr_wdata = LANE_STAT_REG;  end
      S_POLL_RD:   begin cr_req = 1'b1; cr_op = CR_READ;        cr_wdata = 16'h0000;       end
      default: ;
    endcase
  end

  assign busy   = (state != S_IDLE);
  assign done   = done_q;
  assign result = res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      res_q    <= RES_NONE;
      done_q   <= 1'b0;
      pwr_down <= 1'b1;
      soft_rst <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (cmd_fail) begin
        state  <= S_IDLE;
        res_q  <= RES_LINKERR;
        done_q <= 1'b1;
      end else begin
        unique case (state)
          S_IDLE: if (start) begin
            res_q <= RES_NONE;
            if (pre_en) begin
              pwr_down <= 1'b0;
              state    <= S_PRE_RLO;
            end else begin
              state    <= S_RST_ADDR;
            end
          end
          S_PRE_RLO: begin soft_rst <= 1'b0; state <= S_PRE_RHI; end
          S_PRE_RHI: begin soft_rst <= 1'b1; state <= S_RST_ADDR; end
          S_RST_ADDR:  if (cmd_ack) state <= S_RST_WR;
          S_RST_WR:    if (cmd_ack) state <= S_GAP;
          S_GAP:       if (gap_expired) state <= S_POLL_ADDR;
          S_POLL_ADDR: if (cmd_ack) state <= S_POLL_RD;
          S_POLL_RD: begin
            if (poll_hit) begin
              state <= S_IDLE; res_q <= RES_LOCKED; done_q <= 1'b1;
            end else if (poll_miss) begin
              if (poll_last) begin
                state <= S_IDLE; res_q <= RES_TIMEOUT; done_q <= 1'b1;
              end else begin
                state <= S_GAP;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/physeq_sva.sv
`timescale 1ns/1ps
module physeq_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [1:0]  result,
  input logic        pwr_down,
  input logic        cr_req,
  input logic [1:0]  cr_op,
  input logic [15:0] cr_wdata,
  input logic        cr_done,
  input logic        cr_err,
  input logic [15:0] cr_rdata
);
  // R1: no command is ever requested while idle
  a_r1_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cr_req);

  // R10: done is a single-cycle pulse and comes with busy low
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8: a failed command ends the request stream with a link error
  a_r8_err_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_req && cr_done && cr_err) |=> (!cr_req && done && result == 2'd3));

  // R4: the write-without-acknowledge always carries the reset value
  a_r4_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_req && cr_op == 2'd1) |-> cr_wdata == 16'h0001);

  // R6: a successful read with the lock bit set ends the run as locked
  a_r6_lock_result: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_req && cr_done && !cr_err && cr_op == 2'd2 && cr_rdata[1])
      |=> (done && result == 2'd1));

  // R2: once the power-down control is released it stays released
  a_r2_pd_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_down |=> !pwr_down);
endmodule

bind physeq_reset_lock physeq_sva u_sva (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .result(result),
  .pwr_down(pwr_down), .cr_req(cr_req), .cr_op(cr_op), .cr_wdata(cr_wdata),
  .cr_done(cr_done), .cr_err(cr_err), .cr_rdata(cr_rdata)
);

// File: tb/physeq_reset_lock_tb_top.sv
`timescale 1ns/1ps
module physeq_reset_lock_tb_top;
  localparam int GAP   = 6;
  localparam int POLLS = 5;
  localparam int LAT   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        pre_en = 1'b0;
  logic        busy, done, pwr_down, soft_rst, cr_req;
  logic [1:0]  result, cr_op;
  logic [15:0] cr_wdata;
  logic        cr_done = 1'b0;
  logic        cr_err = 1'b0;
  logic [15:0] cr_rdata = 16'h0000;

  always #5 clk = ~clk;

  physeq_reset_lock #(.GAP_CYC(GAP), .MAX_POLLS(POLLS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pre_en(pre_en),
    .busy(busy), .done(done), .result(result),
    .pwr_down(pwr_down), .soft_rst(soft_rst),
    .cr_req(cr_req), .cr_op(cr_op), .cr_wdata(cr_wdata),
    .cr_done(cr_done), .cr_err(cr_err), .cr_rdata(cr_rdata)
  );

  typedef struct { logic [1:0] op; logic [15:0] data; int gap; } item_t;
  item_t exp_q[$];

  int total = 0;
  int bad = 0;
  int lock_at = -1;
  int err_at = -1;
  int txn_idx = 0;
  int rd_idx = 0;
  int done_seen = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // register-master model + scoreboard monitor
  initial begin : master
    int idle;
    idle = 0;
    @(negedge clk);
    forever begin
      if (cr_req) begin
        item_t e;
        if (exp_q.size() == 0) begin
          chk(0, "R8 unexpected command", int'(cr_op), 0);
        end else begin
          e = exp_q.pop_front();
          chk(cr_op == e.op, "R4/R5 command op", int'(cr_op), int'(e.op));
          if (e.op != 2'd2)
            chk(cr_wdata == e.data, "R4/R5 command data", int'(cr_wdata), int'(e.data));
          if (e.gap >= 0)
            chk(idle == e.gap, "R5 idle gap before poll", idle, e.gap);
        end
        repeat (LAT - 1) @(negedge clk);
        cr_err   = (txn_idx == err_at);
        cr_rdata = 16'h0000;
        if (cr_op == 2'd2) begin
          cr_rdata = (rd_idx == lock_at) ? 16'h0002 : 16'hFFFD;
          rd_idx++;
        end
        txn_idx++;
        cr_done = 1'b1;
        @(negedge clk);
        cr_done = 1'b0;
        cr_err  = 1'b0;
        idle = 0;
      end else begin
        idle++;
        @(negedge clk);
      end
    end
  end

  always @(posedge clk) if (done) done_seen++;

  task automatic push(input logic [1:0] op, input logic [15:0] d, input int g);
    item_t it;
    it.op = op; it.data = d; it.gap = g;
    exp_q.push_back(it);
  endtask

  // expected stream: reset address + write, then nreads polls, truncated to keep items
  task automatic plan(input int nreads, input int keep);
    exp_q.delete();
    push(2'd0, 16'h7F3F, -1);
    push(2'd1, 16'h0001, 0);
    for (int i = 0; i < nreads; i++) begin
      push(2'd0, 16'h2003, GAP);
      push(2'd2, 16'h0000, 0);
    end
    while (keep >= 0 && exp_q.size() > keep) void'(exp_q.pop_back());
  endtask

  task automatic run(input bit pre, input int lk, input int er, input int nreads,
                     input int keep, input int exp_res, input bit dbl_start, input string tag);
    logic pd0, sr0;
    int n;
    lock_at = lk; err_at = er; txn_idx = 0; rd_idx = 0; done_seen = 0;
    plan(nreads, keep);
    pd0 = pwr_down; sr0 = soft_rst;
    pre_en = pre; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    if (pre) begin
      chk(pwr_down == 0 && soft_rst == 1, "R2 step1 pd low", {pwr_down, soft_rst}, 2'b01);
      @(negedge clk);
      chk(pwr_down == 0 && soft_rst == 0, "R2 step2 srst low", {pwr_down, soft_rst}, 2'b00);
      @(negedge clk);
      chk(soft_rst == 1 && cr_req == 1, "R2 step3 srst high + req", {soft_rst, cr_req}, 2'b11);
    end else begin
      chk(cr_req == 1, "R3 first request next cycle", int'(cr_req), 1);
      chk(pwr_down == pd0 && soft_rst == sr0, "R3 controls untouched",
          {pwr_down, soft_rst}, {pd0, sr0});
    end
    n = 0;
    while (!done && n < 5000) begin
      if (dbl_start && n == 10) start = 1'b1;
      if (dbl_start && n == 11) start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(done == 1 && result == exp_res[1:0], {tag, " result"}, int'(result), exp_res);
    chk(busy == 0, "R10 busy low at done", int'(busy), 0);
    @(negedge clk);
    chk(done == 0, "R10 done one cycle", int'(done), 0);
    repeat (20) @(negedge clk);
    chk(done_seen == 1, "R9 single done pulse", done_seen, 1);
    chk(exp_q.size() == 0, {tag, " all expected commands seen"}, exp_q.size(), 0);
    chk(cr_req == 0, "R8 no request after end", int'(cr_req), 0);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(pwr_down == 1 && soft_rst == 1, "R1 reset controls", {pwr_down, soft_rst}, 2'b11);
    chk(!busy && !done && !cr_req && result == 0, "R1 reset outputs",
        {busy, done, cr_req, result}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 + R6: no pre-stage, lock on first read
    run(0, 0, -1, 1, -1, 1, 0, "R6 lock first poll");
    // R2 + R6: pre-stage, filler 0xFFFD ignored, lock on third read
    run(1, 2, -1, 3, -1, 1, 0, "R6 lock third poll");
    // R7: never locks -> exactly POLLS reads
    run(0, -1, -1, POLLS, -1, 2, 0, "R7 timeout");
    // R8: error on first read (txn 3)
    run(0, -1, 3, 1, 4, 3, 0, "R8 error on read");
    // R8: error on very first address command
    run(0, -1, 0, 0, 1, 3, 0, "R8 error on first cmd");
    // R9: extra start during a run is ignored
    run(0, 1, -1, 2, -1, 1, 1, "R9 start while busy");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule